// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

The block runs one whole I2C master message, either a read or a write, on a byte-level bus engine. The engine raises a flag and reports an 8-bit status code each time a bus step completes. The sequencer reads that code and decides the next step. Depending on the step, it writes the engine's data register, its control register, or both. A transfer starts with a START condition. One address byte follows for a 7-bit target, or two for a 10-bit target. Data bytes then move in the requested direction, and the transfer always ends with a STOP.

The client side is a single-cycle request strobe. It carries the target address, an address-width select, a direction and a byte count. Outgoing bytes are taken from `wr_data`, and `wr_take` marks each byte as it is consumed. Incoming bytes appear on `rd_data` qualified by `rd_valid`. When the transfer finishes, `done` pulses for one cycle and `err` holds the outcome: 0 for success, 1 when the target did not acknowledge, 2 for an unexpected engine status. An unexpected status also produces a soft-reset pulse to the engine. A read of length zero works as a presence probe.

Every control write keeps the engine enabled. The control fields it drives are START, STOP and the acknowledge-enable bit.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the sequencer is idle, and `ctl_we`, `dat_we`, `wr_take`, `rd_valid`, `done` and `eng_reset` are all low.
- R2: In idle, `req_valid` produces one control write with `ctl_start`=1 and `ctl_ack`=1. A `req_valid` that arrives while a transfer is in progress is ignored.
- R3: On status 0x08 or 0x10, the data register gets the first address byte. For a 7-bit target this byte is {addr[6:0], dir}, where dir is 1 for a read.
- R4: For a 10-bit target, the first address byte is {5'b11110, addr[9:8], dir}. When status 0x18 or 0x40 follows, the second byte, addr[7:0], is sent.
- R5: On a write, each status of 0x18 (7-bit), 0xD0 or 0x28 sends the next byte from `wr_data` with a `wr_take` pulse while bytes remain. Once no bytes remain, it sends STOP and finishes with `err`=0.
- R6: On a read, each status of 0x50 delivers `eng_rdata` on `rd_data` with `rd_valid`. Every control write that requests a byte has `ctl_ack`=1, except the one that requests the final byte, which has `ctl_ack`=0.
- R7: Status 0x58 delivers the last byte and sends STOP in the same control write, then finishes with `err`=0.
- R8: Status 0x20, 0x30 or 0x48 sends STOP and finishes with `err`=1.
- R9: A read of length zero sends STOP directly after the address is acknowledged, with no byte requested, and finishes with `err`=0.
- R10: Any status not listed above sends STOP, pulses `eng_reset` in the same cycle, and finishes with `err`=2.
- R11: An engine flag that arrives while idle produces only a STOP write. It does not pulse `done`.
- R12: `done` is a single-cycle pulse, and `err` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted in idle |
| req_addr | input | 10 | Target address |
| req_ten | input | 1 | 1 selects 10-bit addressing |
| req_read | input | 1 | 1 for read, 0 for write |
| req_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Next outgoing byte |
| wr_take | output | 1 | Outgoing byte consumed |
| rd_valid | output | 1 | Incoming byte valid |
| rd_data | output | 8 | Incoming byte |
| done | output | 1 | Transfer finished (one cycle) |
| err | output | 2 | Outcome code: 0 ok, 1 no device, 2 I/O error |
| eng_flag | input | 1 | Engine step-complete flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine receive data |
| ctl_we | output | 1 | Engine control register write |
| ctl_start | output | 1 | Control field: issue START |
| ctl_stop | output | 1 | Control field: issue STOP |
| ctl_ack | output | 1 | Control field: acknowledge received bytes |
| dat_we | output | 1 | Engine data register write |
| dat_wdata | output | 8 | Byte for the data register |
| eng_reset | output | 1 | Engine soft-reset pulse |

## Verification
The assertions check the cycle-level rules on every cycle. These are: `done` lasts one cycle; START and STOP are never requested together; a START only follows a request; each consumed outgoing byte is paired with a data write; and an engine soft reset always coincides with a STOP and an I/O-error completion. Several behaviours can only be shown by the bench's scenarios, played against a modelled engine and target. These are the exact address bytes for both address widths, the order and count of data bytes, the clearing of acknowledge on exactly the last read request, the probe behaviour, the no-device and error paths, and requests that are ignored while busy.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_WSTART, S_WADDR1, S_WADDR2, S_WSACK, S_WSDATA
    } seq_state_t;

    typedef enum logic [3:0] {
        A_ADDR1, A_ADDR2, A_SEND, A_CONT, A_RECV, A_RECV_STOP,
        A_STOP, A_NODEV, A_IOERR
    } seq_act_t;

    typedef enum logic [1:0] {
        E_NONE  = 2'd0,
        E_NODEV = 2'd1,
        E_IO    = 2'd2
    } seq_err_t;

    localparam logic [7:0] ST_START    = 8'h08;
    localparam logic [7:0] ST_RSTART   = 8'h10;
    localparam logic [7:0] ST_WA_ACK   = 8'h18;
    localparam logic [7:0] ST_WA_NACK  = 8'h20;
    localparam logic [7:0] ST_WD_ACK   = 8'h28;
    localparam logic [7:0] ST_WD_NACK  = 8'h30;
    localparam logic [7:0] ST_RA_ACK   = 8'h40;
    localparam logic [7:0] ST_RA_NACK  = 8'h48;
    localparam logic [7:0] ST_RD_ACK   = 8'h50;
    localparam logic [7:0] ST_RD_NACK  = 8'h58;
    localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
    localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

    typedef struct packed {
        logic [7:0] first;
        logic [7:0] second;
    } addr_pair_t;

    function automatic addr_pair_t form_addr(logic [9:0] a, logic ten, logic rd);
        addr_pair_t p;
        if (ten) begin
            p.first  = {5'b11110, a[9:8], rd};
            p.second = a[7:0];
        end else begin
            p.first  = {a[6:0], rd};
            p.second = 8'h00;
        end
        return p;
    endfunction

    function automatic seq_err_t act_to_err(seq_act_t a);
        if (a == A_NODEV) return E_NODEV;
        if (a == A_IOERR) return E_IO;
        return E_NONE;
    endfunction

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
    import i2c_seq_pkg::*;
(
    input  logic [9:0]  addr,
    input  logic        ten,
    input  logic        rd,
    output addr_pair_t  pair
);
    always_comb pair = form_addr(addr, ten, rd);
endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  seq_state_t        st,
    input  logic [7:0]        status,
    input  logic              ten,
    input  logic [LEN_W-1:0]  left,
    output seq_act_t          act,
    output seq_state_t        nxt,
    output logic              dec,
    output logic              clr_ack
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    logic none_left;
    assign none_left = (left == '0);

    always_comb begin
        act     = A_STOP;
        nxt     = S_IDLE;
        dec     = 1'b0;
        clr_ack = 1'b0;
        if (st != S_IDLE) begin
            case (status)
                ST_START, ST_RSTART: begin
                    act = A_ADDR1;
                    nxt = S_WADDR1;
                end
                ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
                    if (status == ST_WA_ACK && ten) begin
                        act = A_ADDR2;
                        nxt = S_WADDR2;
                    end else if (!none_left) begin
                        act = A_SEND;
                        nxt = S_WSACK;
                        dec = 1'b1;
                    end
                end
                ST_RA_ACK, ST_RA2_ACK: begin
                    if (status == ST_RA_ACK && ten) begin
                        act = A_ADDR2;
                        nxt = S_WADDR2;
                    end else if (!none_left) begin
                        act     = A_CONT;
                        nxt     = S_WSDATA;
                        clr_ack = (left == ONE);
                    end
                end
                ST_RD_ACK: begin
                    act     = A_RECV;
                    nxt     = S_WSDATA;
                    dec     = !none_left;
                    clr_ack = (left <= TWO);
                end
                ST_RD_NACK: act = A_RECV_STOP;
                ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: act = A_NODEV;
                default: act = A_IOERR;
            endcase
        end
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [9:0]        req_addr,
    input  logic              req_ten,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [1:0]        err,
    input  logic              eng_flag,
    input  logic [7:0]        eng_status,
    input  logic [7:0]        eng_rdata,
    output logic              ctl_we,
    output logic              ctl_start,
    output logic              ctl_stop,
    output logic              ctl_ack,
    output logic              dat_we,
    output logic [7:0]        dat_wdata,
    output logic              eng_reset
);
    seq_state_t        state;
    logic [LEN_W-1:0]  left;
    logic              ack_q;
    logic [9:0]        addr_q;
    logic              ten_q;
    logic              rd_q;
    seq_err_t          err_q;

    addr_pair_t        pair;
    seq_act_t          act;
    seq_state_t        nxt;
    logic              dec;
    logic              clr_ack;
    logic              accept;
    logic              ack_nx;

    i2c_seq_addr u_addr (
        .addr (addr_q),
        .ten  (ten_q),
        .rd   (rd_q),
        .pair (pair)
    );

    i2c_seq_decode #(.LEN_W(LEN_W)) u_dec (
        .st      (state),
        .status  (eng_status),
        .ten     (ten_q),
        .left    (left),
        .act     (act),
        .nxt     (nxt),
        .dec     (dec),
        .clr_ack (clr_ack)
    );

    // A step is taken once per flag; the control write just issued clears it.
    assign accept = eng_flag && !ctl_we;
    assign ack_nx = ack_q && !clr_ack;
    assign err    = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            left      <= '0;
            ack_q     <= 1'b0;
            addr_q    <= '0;
            ten_q     <= 1'b0;
            rd_q      <= 1'b0;
            err_q     <= E_NONE;
            wr_take   <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            done      <= 1'b0;
            ctl_we    <= 1'b0;
            ctl_start <= 1'b0;
            ctl_stop  <= 1'b0;
            ctl_ack   <= 1'b0;
            dat_we    <= 1'b0;
            dat_wdata <= '0;
            eng_reset <= 1'b0;
        end else begin
            wr_take   <= 1'b0;
            rd_valid  <= 1'b0;
            done      <= 1'b0;
            ctl_we    <= 1'b0;
            ctl_start <= 1'b0;
            ctl_stop  <= 1'b0;
            dat_we    <= 1'b0;
            eng_reset <= 1'b0;
            if (accept) begin
                ctl_we  <= 1'b1;
                ctl_ack <= ack_nx;
                ack_q   <= ack_nx;
                state   <= nxt;
                if (dec) left <= left - LEN_W'(1);
                case (act)
                    A_ADDR1: begin
                        dat_we    <= 1'b1;
                        dat_wdata <= pair.first;
                    end
                    A_ADDR2: begin
                        dat_we    <= 1'b1;
                        dat_wdata <= pair.second;
                    end
                    A_SEND: begin
                        dat_we    <= 1'b1;
                        dat_wdata <= wr_data;
                        wr_take   <= 1'b1;
                    end
                    A_CONT: ;
                    A_RECV: begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rdata;
                    end
                    A_RECV_STOP: begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rdata;
                        ctl_stop <= 1'b1;
                    end
                    A_IOERR: begin
                        ctl_stop  <= 1'b1;
                        eng_reset <= 1'b1;
                    end
                    default: ctl_stop <= 1'b1;
                endcase
                if (state != S_IDLE && nxt == S_IDLE) begin
                    done  <= 1'b1;
                    err_q <= act_to_err(act);
                end
            end else if (req_valid && state == S_IDLE) begin
                addr_q    <= req_addr;
                ten_q     <= req_ten;
                rd_q      <= req_read;
                left      <= req_len;
                ack_q     <= 1'b1;
                ctl_we    <= 1'b1;
                ctl_start <= 1'b1;
                ctl_ack   <= 1'b1;
                state     <= S_WSTART;
            end
        end
    end

    // R12: completion is a single-cycle pulse
    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: START and STOP are never requested in one control write
    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_we |-> !(ctl_start && ctl_stop));

    // R2: a START is only issued in answer to a request strobe
    p_start_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_start |-> $past(req_valid));

    // R5: every consumed outgoing byte goes to the data register, never with STOP
    p_take_pairs_data_r5: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (dat_we && ctl_we && !ctl_stop));

    // R10: engine soft reset always rides with STOP and an I/O-error completion
    p_reset_with_stop_r10: assert property (@(posedge clk) disable iff (rst)
        eng_reset |-> (ctl_we && ctl_stop && done && err == E_IO));

    // R8: a no-device completion always carries STOP
    p_nodev_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (done && err == E_NODEV) |-> (ctl_we && ctl_stop));
endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [9:0]       req_addr = '0;
    logic             req_ten = 1'b0;
    logic             req_read = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0]       wr_data;
    logic             wr_take, rd_valid, done;
    logic [7:0]       rd_data;
    logic [1:0]       err;
    logic             eng_flag = 1'b0;
    logic [7:0]       eng_status = 8'hF8;
    logic [7:0]       eng_rdata = 8'h00;
    logic             ctl_we, ctl_start, ctl_stop, ctl_ack, dat_we, eng_reset;
    logic [7:0]       dat_wdata;

    i2c_xfer_seq #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ten(req_ten), .req_read(req_read), .req_len(req_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .err(err), .eng_flag(eng_flag),
        .eng_status(eng_status), .eng_rdata(eng_rdata), .ctl_we(ctl_we),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_ack(ctl_ack),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .eng_reset(eng_reset)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // ---------------- bench configuration (written by tasks only) ----------
    bit   cfg_rd = 0, cfg_ten = 0, cfg_present = 1;
    int   cfg_nack_abs = -1, cfg_ovr_abs = -1;
    logic [7:0] cfg_ovr_st = 8'h38;
    bit   inj_tog = 0;
    logic [7:0] inj_st = 8'h28;
    logic [7:0] wbuf [16];
    int   wibase = 0;

    // ---------------- engine and target model -----------------------------
    int   wcnt = 0, stop_cnt = 0, start_cnt = 0, rst_cnt = 0;
    int   ack1_cnt = 0, ack0_cnt = 0, rseq = 0, dcnt = 0, evn = 0;
    int   ph = 0, cd = 0;
    bit   inj_seen = 0;
    logic [7:0] pst = 8'h00, prd = 8'h00, st_t;
    logic [7:0] wlog [64];

    function automatic logic [7:0] pat(int n);
        return 8'((n * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            eng_flag <= 1'b0;
            cd <= 0;
            ph <= 0;
        end else begin
            if (cd == 1) begin
                eng_flag   <= 1'b1;
                eng_status <= pst;
                eng_rdata  <= prd;
            end
            if (cd != 0) cd <= cd - 1;
            if (inj_tog != inj_seen) begin
                inj_seen   <= inj_tog;
                eng_flag   <= 1'b1;
                eng_status <= inj_st;
            end
            if (ctl_we) begin
                eng_flag <= 1'b0;
                if (eng_reset) rst_cnt <= rst_cnt + 1;
                if (ctl_stop) begin
                    stop_cnt <= stop_cnt + 1;
                    ph <= 0;
                    cd <= 0;
                end else begin
                    st_t = 8'hF8;
                    if (ctl_start) begin
                        start_cnt <= start_cnt + 1;
                        ph <= 1;
                        st_t = 8'h08;
                    end else if (dat_we) begin
                        wlog[wcnt % 64] <= dat_wdata;
                        wcnt <= wcnt + 1;
                        if (ph == 1) begin
                            if (!cfg_present) st_t = cfg_rd ? 8'h48 : 8'h20;
                            else st_t = cfg_rd ? 8'h40 : 8'h18;
                            ph <= cfg_ten ? 2 : (cfg_rd ? 4 : 3);
                        end else if (ph == 2) begin
                            st_t = cfg_rd ? 8'hE0 : 8'hD0;
                            ph <= cfg_rd ? 4 : 3;
                        end else begin
                            st_t = (dcnt == cfg_nack_abs) ? 8'h30 : 8'h28;
                            dcnt <= dcnt + 1;
                        end
                    end else begin
                        if (ctl_ack) ack1_cnt <= ack1_cnt + 1;
                        else ack0_cnt <= ack0_cnt + 1;
                        prd  <= pat(rseq);
                        rseq <= rseq + 1;
                        st_t = ctl_ack ? 8'h50 : 8'h58;
                    end
                    if (evn == cfg_ovr_abs) st_t = cfg_ovr_st;
                    evn <= evn + 1;
                    pst <= st_t;
                    cd  <= 3;
                end
            end
        end
    end

    // ---------------- client-side collectors ------------------------------
    int widx = 0, done_cnt = 0, rcv_cnt = 0;
    logic [1:0] last_err = 2'd0;
    logic [7:0] rlog [64];
    assign wr_data = wbuf[(widx - wibase) & 15];

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_take) widx <= widx + 1;
            if (done) begin
                done_cnt <= done_cnt + 1;
                last_err <= err;
            end
            if (rd_valid) begin
                rlog[rcv_cnt % 64] <= rd_data;
                rcv_cnt <= rcv_cnt + 1;
            end
        end
    end

    // ---------------- checking helpers ------------------------------------
    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_first(logic [9:0] a, bit ten, bit rd);
        if (ten) return {5'b11110, a[9:8], rd};
        return {a[6:0], rd};
    endfunction

    task automatic run_xfer(input bit rd, input bit ten, input logic [9:0] addr,
                            input int len, input bit present, input int nack_k,
                            input int ovr_k, input logic [7:0] ovr_st,
                            input bit poke);
        int wb, sb, a1b, a0b, rqb, rcb, db, rsb, stb, t, nd, eerr, nbytes;
        logic [7:0] wsave [16];
        cfg_rd = rd; cfg_ten = ten; cfg_present = present;
        cfg_nack_abs = (nack_k >= 0) ? dcnt + nack_k : -1;
        cfg_ovr_abs  = (ovr_k >= 0) ? evn + ovr_k : -1;
        cfg_ovr_st   = ovr_st;
        for (int i = 0; i < 16; i++) begin
            wbuf[i]  = 8'($urandom);
            wsave[i] = wbuf[i];
        end
        wibase = widx;
        wb = wcnt; sb = stop_cnt; a1b = ack1_cnt; a0b = ack0_cnt; rqb = rseq;
        rcb = rcv_cnt; db = done_cnt; rsb = rst_cnt; stb = start_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_ten = ten; req_read = rd;
        req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = ~addr; req_ten = ~ten;
            req_read = ~rd; req_len = 8'd7;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == db && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk("R12 one completion per transfer", done_cnt - db, 1);
        chk("R2 one START per request", start_cnt - stb, 1);
        // expected outcome
        if (ovr_k == 0) eerr = 2;
        else if (!present) eerr = 1;
        else if (!rd && nack_k >= 0 && nack_k < len) eerr = 1;
        else eerr = 0;
        chk("R5/R8/R10 error code", int'(last_err), eerr);
        chk("R8/R10 single STOP", stop_cnt - sb, 1);
        chk("R10 engine reset count", rst_cnt - rsb, (eerr == 2) ? 1 : 0);
        // bytes written to the engine data register
        if (ovr_k == 0) nbytes = 0;
        else begin
            nbytes = 1;
            if (present && ten) nbytes++;
            if (present && !rd) nbytes += (nack_k >= 0 && nack_k < len) ? nack_k + 1 : len;
        end
        chk("R5 bytes written", wcnt - wb, nbytes);
        if (ovr_k != 0) begin
            if (ten) chk("R4 first address byte", int'(wlog[wb % 64]), int'(exp_first(addr, 1, rd)));
            else chk("R3 first address byte", int'(wlog[wb % 64]), int'(exp_first(addr, 0, rd)));
            if (present && ten)
                chk("R4 second address byte", int'(wlog[(wb + 1) % 64]), int'(addr[7:0]));
            nd = (present && ten) ? 2 : 1;
            for (int i = nd; i < nbytes && i < wcnt - wb; i++)
                chk("R5 data byte", int'(wlog[(wb + i) % 64]), int'(wsave[i - nd]));
        end
        // read side
        nd = (present && rd && ovr_k != 0) ? len : 0;
        chk("R6 bytes delivered", rcv_cnt - rcb, nd);
        for (int i = 0; i < nd && i < rcv_cnt - rcb; i++)
            chk("R6/R7 read byte value", int'(rlog[(rcb + i) % 64]), int'(pat(rqb + i)));
        chk("R6 requests with ACK", ack1_cnt - a1b, (nd > 0) ? nd - 1 : 0);
        chk("R6/R9 requests without ACK", ack0_cnt - a0b, (nd > 0) ? 1 : 0);
    endtask

    // ---------------- watchdog --------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // ---------------- main sequence ---------------------------------------
    initial begin
        int sb, db, wb;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctl_we idle", int'(ctl_we), 0);
        chk("R1 dat_we idle", int'(dat_we), 0);
        chk("R1 done idle", int'(done), 0);
        chk("R1 wr_take/rd_valid idle", int'(wr_take | rd_valid), 0);
        chk("R1 eng_reset idle", int'(eng_reset), 0);

        // directed corner cases
        run_xfer(0, 0, 10'h05A, 3, 1, -1, -1, 8'h38, 0); // R3 R5 7-bit write
        run_xfer(0, 1, 10'h2C7, 2, 1, -1, -1, 8'h38, 0); // R4 R5 10-bit write
        run_xfer(1, 0, 10'h033, 4, 1, -1, -1, 8'h38, 0); // R6 R7 read
        run_xfer(1, 1, 10'h1F0, 1, 1, -1, -1, 8'h38, 0); // R4 R7 single-byte 10-bit read
        run_xfer(1, 0, 10'h050, 0, 1, -1, -1, 8'h38, 0); // R9 probe present
        run_xfer(1, 0, 10'h051, 0, 0, -1, -1, 8'h38, 0); // R8 probe absent
        run_xfer(0, 1, 10'h3FF, 2, 0, -1, -1, 8'h38, 0); // R8 10-bit absent write
        run_xfer(0, 0, 10'h011, 4, 1, 1, -1, 8'h38, 0);  // R8 data NACK
        run_xfer(0, 0, 10'h022, 0, 1, -1, -1, 8'h38, 0); // R5 zero-length write
        run_xfer(0, 0, 10'h044, 2, 1, -1, 0, 8'h38, 0);  // R10 bad status
        run_xfer(1, 0, 10'h066, 2, 1, -1, 0, 8'h00, 0);  // R10 bus-error status
        run_xfer(0, 0, 10'h077, 3, 1, -1, -1, 8'h38, 1); // R2 request while busy

        // R11: flag while idle produces STOP only
        sb = stop_cnt; db = done_cnt; wb = wcnt;
        inj_st = 8'h28;
        inj_tog = ~inj_tog;
        repeat (20) @(negedge clk);
        chk("R11 idle flag STOP", stop_cnt - sb, 1);
        chk("R11 idle flag no done", done_cnt - db, 0);
        chk("R11 idle flag no data write", wcnt - wb, 0);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            bit rd, ten, pr;
            int len, nk;
            rd  = 1'($urandom % 2);
            ten = 1'($urandom % 2);
            len = $urandom % 6;
            pr  = ($urandom % 5) != 0;
            nk  = (!rd && ($urandom % 3) == 0) ? int'($urandom % 4) : -1;
            run_xfer(rd, ten, 10'($urandom), len, pr, nk, -1, 8'h38, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule